// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short, arbitrary command against a serial flash over a single-data-line SPI link. Software writes the outgoing bytes into six transmit slots and the total number of SCK cycles into a bit-count register. It then starts the transfer by setting a command bit or by pulsing `startPulse`. The block lowers chip select and sends the transmit slots MSB first, beginning at the highest slot. Once the slots run out it sends zeros. Every bit seen on MISO is shifted into a ten-byte receive bank. Because the length is a count of bits and not of bytes, one transfer can hold opcode, address, dummy and read-back bytes together.

A second command bit starts a status-register write. On the wire this is the same transfer. When it ends, it can also set a sticky interrupt flag, gated by an enable bit.

The link runs in SPI mode 0. SCK idles low, MOSI changes after falling edges and MISO is sampled on rising edges. Each SCK half period lasts `SCK_HALF` clock cycles. Chip select falls one SCK period before the first rising edge and rises one SCK period after the last falling edge.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, csNOut is 1, sckOut, mosiOut and irqOut are 0, and every register word 0 to 19 reads 0.
- R2: Transmit slot i sits at word 2+i. The first bit on MOSI is bit 7 of slot 5, then the rest of slot 5, then slot 4 and so on down to slot 0, MSB first. Every bit after the 48th is 0.
- R3: The bit-count register at word 1 sets the exact number of SCK rising edges in a transfer. Each SCK period lasts 2*SCK_HALF clock cycles.
- R4: Receive slot i is read at word 8+i. The bank is one shift register: each MISO bit sampled on a rising edge enters bit 0 of slot 0, and older bits move up through the slots. Slot 0 therefore holds the last byte received and slot 1 the byte before it.
- R5: Writing 1 to bit 2 of the command word (word 0), or pulsing startPulse, starts a transfer. Bit 2 reads 1 until the clock edge on which csNOut returns high, and reads 0 from then on.
- R6: csNOut falls on the launch edge, and the first SCK rise follows 2*SCK_HALF cycles later. csNOut rises 2*SCK_HALF cycles after the last SCK fall. SCK is never high while csNOut is high.
- R7: While a command bit is set, writes to the command word and startPulse have no effect.
- R8: Writing 1 to bit 5 of the command word starts a status-register write. It puts the same sequence on the wire as R2 to R6, and bit 5 reads 1 while it runs. When it ends, if bit 5 of the enable word (word 18) is 1, then bit 5 of the status word (word 19) becomes 1, and irqOut follows that bit. The status bit stays set across later transfers until a 1 is written to it. If the enable bit is 0, the status bit is not set.
- R9: A launch request made while the bit count is 0 is ignored: the command bit stays 0 and csNOut stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on regAddr |
| startPulse | input | 1 | One-cycle request to start a transfer |
| sckOut | output | 1 | SPI clock |
| csNOut | output | 1 | SPI chip select, active low |
| mosiOut | output | 1 | SPI data to the flash |
| misoIn | input | 1 | SPI data from the flash |
| irqOut | output | 1 | Sticky status-write completion flag |

## Verification
A transfer of n bits launched on edge E0 has a fixed timeline with H = SCK_HALF:
- chip select is low at the sample right after E0;
- the first SCK high appears at the sample after edge E0+2H;
- the last SCK high appears at the sample after edge E0+2Hn+H-1;
- chip select and the command bit return at edge E0+2Hn+3H.

The bench takes one sample on the falling clock edge after every rising edge. It expects each event at exactly that sample index and checks that the command bit still reads 1 on the sample just before release. Receive slots, the interrupt status and the MOSI bits captured by the flash model are read only after chip select has risen.

// File: rtl/spi_cmdsh_pkg.sv
package spi_cmdsh_pkg;
  localparam int BYTE_W  = 8;
  localparam int RUN_BIT = 2;
  localparam int SRW_BIT = 5;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
  } shStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } shState_t;
endpackage

// File: rtl/spi_cmdsh_regs.sv
module spi_cmdsh_regs
  import spi_cmdsh_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int TX_SLOTS = 6,
  parameter int RX_SLOTS = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic [AW-1:0]              regAddr,
  input  logic [DW-1:0]              regWrData,
  output logic [DW-1:0]              regRdData,
  input  logic                       startPulse,
  input  logic [RX_SLOTS*BYTE_W-1:0] rxBank,
  output logic [TX_SLOTS*BYTE_W-1:0] txBank,
  output logic [DW-1:0]              bitCount,
  output logic                       launch,
  input  logic                       done,
  output logic                       irqOut
);
  localparam int CMD_ADDR = 0;
  localparam int CNT_ADDR = 1;
  localparam int TX_BASE  = 2;
  localparam int RX_BASE  = TX_BASE + TX_SLOTS;
  localparam int IEN_ADDR = RX_BASE + RX_SLOTS;
  localparam int IST_ADDR = IEN_ADDR + 1;

  logic [DW-1:0] cmdQ;
  logic [DW-1:0] cntQ;
  logic          ienQ;
  logic          istQ;
  logic          busy;
  logic          cmdWr;
  logic          reqStat;
  logic          reqProg;
  logic          launchStat;

  assign busy       = cmdQ[RUN_BIT] | cmdQ[SRW_BIT];
  assign cmdWr      = regWe && (regAddr == AW'(CMD_ADDR));
  assign reqStat    = cmdWr && regWrData[SRW_BIT];
  assign reqProg    = (cmdWr && regWrData[RUN_BIT]) || startPulse;
  assign launch     = !busy && (cntQ != '0) && (reqStat || reqProg);
  assign launchStat = launch && reqStat;
  assign bitCount   = cntQ;
  assign irqOut     = istQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0;
    end else if (done) begin
      cmdQ <= '0;
    end else if (launch) begin
      cmdQ          <= '0;
      cmdQ[SRW_BIT] <= launchStat;
      cmdQ[RUN_BIT] <= !launchStat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ienQ <= 1'b0;
    end else if (regWe) begin
      if (regAddr == AW'(CNT_ADDR)) cntQ <= regWrData;
      if (regAddr == AW'(IEN_ADDR)) ienQ <= regWrData[SRW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      istQ <= 1'b0;
    end else if (done && cmdQ[SRW_BIT] && ienQ) begin
      istQ <= 1'b1;
    end else if (regWe && regAddr == AW'(IST_ADDR) && regWrData[SRW_BIT]) begin
      istQ <= 1'b0;
    end
  end

  for (genvar g = 0; g < TX_SLOTS; g++) begin : gTxSlot
    logic [BYTE_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (regWe && regAddr == AW'(TX_BASE + g)) begin
        slotQ <= regWrData[BYTE_W-1:0];
      end
    end
    assign txBank[g*BYTE_W +: BYTE_W] = slotQ;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == AW'(CMD_ADDR)) regRdData = cmdQ;
    if (regAddr == AW'(CNT_ADDR)) regRdData = cntQ;
    if (regAddr == AW'(IEN_ADDR)) regRdData[SRW_BIT] = ienQ;
    if (regAddr == AW'(IST_ADDR)) regRdData[SRW_BIT] = istQ;
    for (int i = 0; i < TX_SLOTS; i++) begin
      if (regAddr == AW'(TX_BASE + i)) regRdData = DW'(txBank[i*BYTE_W +: BYTE_W]);
    end
    for (int i = 0; i < RX_SLOTS; i++) begin
      if (regAddr == AW'(RX_BASE + i)) regRdData = DW'(rxBank[i*BYTE_W +: BYTE_W]);
    end
  end

  // R5
  done_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (cmdQ == '0));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(cmdQ));

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(istQ) |-> $past(done && cmdQ[SRW_BIT] && ienQ));
endmodule

// File: rtl/spi_cmdsh_ctrl.sv
module spi_cmdsh_ctrl
  import spi_cmdsh_pkg::*;
#(
  parameter int DW       = 8,
  parameter int SCK_HALF = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          launch,
  input  logic [DW-1:0] bitCount,
  output shStrobe_t     strobe,
  output logic          sckOut,
  output logic          csNOut,
  output logic          done
);
  localparam int HW = $clog2(2 * SCK_HALF) + 1;

  shState_t      state;
  logic [HW-1:0] tick;
  logic [DW-1:0] remain;
  logic          sckQ;
  logic          csNQ;
  logic          halfEnd;
  logic          fullEnd;

  assign halfEnd = (tick == HW'(SCK_HALF - 1));
  assign fullEnd = (tick == HW'(2 * SCK_HALF - 1));

  always_comb begin
    strobe.load   = launch && (state == ST_IDLE);
    strobe.rise   = ((state == ST_LEAD) && fullEnd) || ((state == ST_LOW) && halfEnd);
    strobe.fall   = (state == ST_HIGH) && halfEnd;
    strobe.finish = (state == ST_TRAIL) && fullEnd;
  end

  assign done   = strobe.finish;
  assign sckOut = sckQ;
  assign csNOut = csNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tick   <= '0;
      remain <= '0;
      sckQ   <= 1'b0;
      csNQ   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          tick <= '0;
          if (launch) begin
            state  <= ST_LEAD;
            csNQ   <= 1'b0;
            remain <= bitCount;
          end
        end
        ST_LEAD: begin
          if (fullEnd) begin
            state <= ST_HIGH;
            sckQ  <= 1'b1;
            tick  <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            sckQ   <= 1'b0;
            tick   <= '0;
            remain <= remain - 1'b1;
            state  <= (remain == DW'(1)) ? ST_TRAIL : ST_LOW;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_LOW: begin
          if (halfEnd) begin
            sckQ  <= 1'b1;
            tick  <= '0;
            state <= ST_HIGH;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (fullEnd) begin
            csNQ  <= 1'b1;
            tick  <= '0;
            state <= ST_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          sckQ  <= 1'b0;
          csNQ  <= 1'b1;
          tick  <= '0;
        end
      endcase
    end
  end

  // Checker-only bookkeeping: rising edges seen against the latched length
  logic [DW:0]   riseSeen;
  logic [DW-1:0] lenQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseSeen <= '0;
      lenQ     <= '0;
    end else if (strobe.load) begin
      riseSeen <= '0;
      lenQ     <= bitCount;
    end else if (strobe.rise) begin
      riseSeen <= riseSeen + 1'b1;
    end
  end

  // R6
  sck_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    sckQ |-> !csNQ);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (csNQ && !sckQ));

  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |-> (riseSeen == {1'b0, lenQ}));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> (bitCount != '0));
endmodule

// File: rtl/spi_cmdsh_dp.sv
module spi_cmdsh_dp
  import spi_cmdsh_pkg::*;
#(
  parameter int TX_SLOTS = 6,
  parameter int RX_SLOTS = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  shStrobe_t                  strobe,
  input  logic [TX_SLOTS*BYTE_W-1:0] txBank,
  input  logic                       misoIn,
  output logic                       mosiOut,
  output logic [RX_SLOTS*BYTE_W-1:0] rxBank
);
  localparam int TXB = TX_SLOTS * BYTE_W;
  localparam int RXB = RX_SLOTS * BYTE_W;

  logic [TXB-1:0] txShift;
  logic [RXB-1:0] rxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= txBank;
    end else if (strobe.fall) begin
      txShift <= {txShift[TXB-2:0], 1'b0};
    end else if (strobe.finish) begin
      txShift <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ <= '0;
    end else if (strobe.rise) begin
      rxQ <= {rxQ[RXB-2:0], misoIn};
    end
  end

  assign mosiOut = txShift[TXB-1];
  assign rxBank  = rxQ;

  // R4
  rx_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rise |=> (rxQ[0] == $past(misoIn)));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmdsh_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int TX_SLOTS = 6,
  parameter int RX_SLOTS = 10,
  parameter int SCK_HALF = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          startPulse,
  output logic          sckOut,
  output logic          csNOut,
  output logic          mosiOut,
  input  logic          misoIn,
  output logic          irqOut
);
  logic [TX_SLOTS*BYTE_W-1:0] txBank;
  logic [RX_SLOTS*BYTE_W-1:0] rxBank;
  logic [DW-1:0]              bitCount;
  logic                       launch;
  logic                       done;
  shStrobe_t                  strobe;

  spi_cmdsh_regs #(
    .AW(AW), .DW(DW), .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS)
  ) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startPulse(startPulse),
    .rxBank(rxBank), .txBank(txBank), .bitCount(bitCount),
    .launch(launch), .done(done), .irqOut(irqOut)
  );

  spi_cmdsh_ctrl #(
    .DW(DW), .SCK_HALF(SCK_HALF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .launch(launch), .bitCount(bitCount),
    .strobe(strobe), .sckOut(sckOut), .csNOut(csNOut), .done(done)
  );

  spi_cmdsh_dp #(
    .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txBank(txBank),
    .misoIn(misoIn), .mosiOut(mosiOut), .rxBank(rxBank)
  );
endmodule

// File: tb/spi_cmd_shifter_test.sv
`timescale 1ns/1ps
module spi_cmd_shifter_test;
  localparam int H      = 2;
  localparam int A_CMD  = 0;
  localparam int A_CNT  = 1;
  localparam int A_TX0  = 2;
  localparam int A_RX0  = 8;
  localparam int A_IEN  = 18;
  localparam int A_IST  = 19;

  typedef struct packed {
    logic [47:0] tx;
    logic [7:0]  n;
    logic [63:0] pat;
    logic        useStart;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{48'h9F0000000000, 8'd32,  64'hC2201811A5A5A5A5, 1'b0},
    '{48'h0312345678AB, 8'd48,  64'h0F0F3C3CF0F01234, 1'b1},
    '{48'h0B00100000FF, 8'd80,  64'h80017FFEDEADBEEF, 1'b0},
    '{48'hA50000000000, 8'd5,   64'hF800000000000000, 1'b0},
    '{48'hFFFFFFFFFFFF, 8'd128, 64'h0123456789ABCDEF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       startPulse = 1'b0;
  logic       sckOut, csNOut, mosiOut, irqOut;
  logic       misoIn = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [127:0] slvPat = '0;
  logic [127:0] mosiCap = '0;
  logic [79:0]  rxModel = '0;
  int           riseCnt = 0;
  int           bitPos = 0;

  always #2.5 clk = ~clk;

  spi_cmd_shifter uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startPulse(startPulse),
    .sckOut(sckOut), .csNOut(csNOut), .mosiOut(mosiOut), .misoIn(misoIn),
    .irqOut(irqOut)
  );

  // Flash model: mode 0, shifts slvPat out MSB first, captures MOSI on rise
  always @(negedge csNOut) begin
    bitPos  = 0;
    riseCnt = 0;
    mosiCap = '0;
    misoIn  = slvPat[127];
  end
  always @(posedge sckOut) begin
    mosiCap = {mosiCap[126:0], mosiOut};
    riseCnt = riseCnt + 1;
  end
  always @(negedge sckOut) begin
    if (!csNOut) begin
      bitPos = bitPos + 1;
      misoIn = (bitPos < 128) ? slvPat[127 - bitPos] : 1'b0;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'(a); regWrData = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = '0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    regAddr = 5'(a);
    #0.5;
    d = regRdData;
  endtask

  task automatic launch(input bit useStart, input logic [7:0] cmdVal);
    @(negedge clk);
    if (useStart) startPulse = 1'b1;
    else begin regWe = 1'b1; regAddr = 5'(A_CMD); regWrData = cmdVal; end
    @(negedge clk);
    startPulse = 1'b0; regWe = 1'b0; regAddr = 5'(A_CMD);
  endtask

  // Called at sample 1 (first falling clock edge after the launch edge)
  task automatic watch(input int n, input bit inject, input logic [47:0] tx);
    int firstRise; int lastHigh; int csRise; int total; int bad;
    logic busyEnd; logic csLow0;
    logic [79:0] rxAct; logic [7:0] d;
    firstRise = 0; lastHigh = 0; csRise = 0; bad = 0; busyEnd = 1'b0;
    total = 2*H*n + 3*H + 2;
    csLow0 = !csNOut;
    for (int k = 1; k <= total; k++) begin
      if (k > 1) @(negedge clk);
      if (inject && k == 6) begin
        regWe = 1'b1; regWrData = 8'h20; startPulse = 1'b1;
      end else begin
        regWe = 1'b0; startPulse = 1'b0;
      end
      regAddr = 5'(A_CMD);
      #0.5;
      if (sckOut && firstRise == 0) firstRise = k;
      if (sckOut) lastHigh = k;
      if (csNOut && csRise == 0) csRise = k;
      if (k == 2*H*n + 3*H) busyEnd = regRdData[2] | regRdData[5];
    end
    chk("R6 cs low at launch", 128'(csLow0), 128'd1);
    chk("R6 lead to first rise", 128'(firstRise), 128'(2*H + 1));
    chk("R3 last high sample", 128'(lastHigh), 128'(2*H*n + H));
    chk("R6 trail to cs release", 128'(csRise), 128'(2*H*n + 3*H + 1));
    chk("R5 busy until release", 128'(busyEnd), 128'd1);
    chk("R3 rising edge count", 128'(riseCnt), 128'(n));
    for (int k = 0; k < n; k++) begin
      if (mosiCap[n-1-k] !== ((k < 48) ? tx[47-k] : 1'b0)) bad++;
    end
    chk("R2 mosi bit order", 128'(bad), 128'd0);
    for (int k = 0; k < n; k++) rxModel = {rxModel[78:0], slvPat[127-k]};
    for (int i = 0; i < 10; i++) begin
      rd(A_RX0 + i, d);
      rxAct[i*8 +: 8] = d;
    end
    chk("R4 receive slots", 128'(rxAct), 128'(rxModel));
    rd(A_CMD, d);
    chk("R5 command bits clear", 128'(d), 128'd0);
  endtask

  task automatic runXfer(input logic [47:0] tx, input int n, input logic [63:0] pat,
                         input bit useStart, input logic [7:0] cmdVal, input bit inject);
    for (int i = 0; i < 6; i++) wr(A_TX0 + i, tx[i*8 +: 8]);
    wr(A_CNT, 8'(n));
    slvPat = {pat, ~pat};
    launch(useStart, cmdVal);
    watch(n, inject, tx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int nz;
    int csHi;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pins in reset", {csNOut, sckOut, mosiOut, irqOut}, 128'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 pins after reset", {csNOut, sckOut, mosiOut, irqOut}, 128'h8);
    nz = 0;
    for (int a = 0; a < 20; a++) begin
      rd(a, d);
      if (d != 0) nz++;
    end
    chk("R1 registers zero", 128'(nz), 128'd0);

    // Table of transfers: R2 R3 R4 R5 R6
    for (int v = 0; v < 5; v++) begin
      runXfer(VECS[v].tx, int'(VECS[v].n), VECS[v].pat, VECS[v].useStart, 8'h04, 1'b0);
    end

    // R8: status write with enable set
    wr(A_IEN, 8'h20);
    runXfer(48'h01_00_00_00_00_00, 16, 64'h5A5A000000000000, 1'b0, 8'h20, 1'b0);
    rd(A_IST, d);
    chk("R8 status bit set", 128'(d), 128'h20);
    chk("R8 irq output", 128'(irqOut), 128'd1);
    runXfer(48'h05_00_00_00_00_00, 8, 64'h0300000000000000, 1'b0, 8'h04, 1'b0);
    rd(A_IST, d);
    chk("R8 status sticky", 128'(d), 128'h20);
    wr(A_IST, 8'h20);
    rd(A_IST, d);
    chk("R8 status cleared", {d, irqOut}, 128'd0);

    // R8: enable clear blocks the status bit
    wr(A_IEN, 8'h00);
    runXfer(48'h01_02_00_00_00_00, 16, 64'h1111000000000000, 1'b0, 8'h20, 1'b0);
    rd(A_IST, d);
    chk("R8 gated by enable", {d, irqOut}, 128'd0);

    // R7: command write and start pulse during a run have no effect
    wr(A_IEN, 8'h20);
    runXfer(48'hAB_CD_EF_00_00_00, 24, 64'h7777777777777777, 1'b0, 8'h04, 1'b1);
    rd(A_IST, d);
    chk("R7 mid-run bit5 write ignored", {d, irqOut}, 128'd0);
    repeat (4) @(negedge clk);
    chk("R7 no second transfer", 128'(csNOut), 128'd1);

    // R9: zero bit count
    wr(A_CNT, 8'd0);
    launch(1'b0, 8'h04);
    rd(A_CMD, d);
    chk("R9 command bit stays clear", 128'(d), 128'd0);
    csHi = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!csNOut || sckOut) csHi = 0;
    end
    chk("R9 no transfer started", 128'(csHi), 128'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule